// File: doc/BRIEF.md
# Signed Dual-Digit Seven-Segment Driver

This block drives a four-digit, common-anode, time-multiplexed seven-segment display so that it shows two independent 4-bit values, X and Y. Each value takes two digit positions: a sign position and a magnitude position. A free-running refresh counter steps through the four positions. In each step exactly one anode enable is pulled low, and the segment lines carry that digit's pattern.

Each value has its own signed-mode flag. With the flag clear, the nibble is shown as a single hexadecimal digit and its sign position stays dark. With the flag set and the top bit of the nibble set, the value is taken as a negative two's-complement number: the sign position lights only the middle bar, and the magnitude position shows the negated nibble. The value source and any switch conditioning sit outside this block. All outputs come from registers, so a change at the inputs reaches the display one clock later.

Top module: `signed_pair_seg_driver`

## Requirements
- R1: While `rst` is high, and at the first clock edge that samples it high, all four `an_n` bits go to 1 and all seven `seg_n` bits go to 1. The first digit enabled after reset is the X sign position.
- R2: After reset, exactly one `an_n` bit is 0 at a time. The positions come in the order `an_n[0]` (X sign), `an_n[1]` (X magnitude), `an_n[2]` (Y sign), `an_n[3]` (Y magnitude), then repeat. Each position lasts 2^(REFRESH_W-2) clocks.
- R3: When a value's signed flag is 0, its magnitude digit shows the raw nibble and its sign digit is blank (`seg_n` = 7'h7F), whether or not bit 3 is set.
- R4: When a value's signed flag is 1 and its bit 3 is 0, its magnitude digit shows the raw nibble and its sign digit is blank.
- R5: When a value's signed flag is 1 and its bit 3 is 1, its magnitude digit shows (16 - value) mod 16. Its sign digit lights only segment g (`seg_n` = 7'b0111111).
- R6: The nibble 4'b1000 shows a minus sign and the digit 8 in signed mode. In unsigned mode it shows a blank sign and the digit 8.
- R7: `seg_n` is active low with bit 0 = a through bit 6 = g. The magnitude digit for 0..F uses the usual hex glyphs. Active-high gfedcba patterns: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R8: The decimal point output `dp_n` is always 1 (off).
- R9: The X and Y sign flags act independently. The same nibble can appear signed on one value and unsigned on the other within one refresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| val_x | input | 4 | First displayed value |
| val_y | input | 4 | Second displayed value |
| sgn_x | input | 1 | Signed-mode flag for `val_x` |
| sgn_y | input | 1 | Signed-mode flag for `val_y` |
| seg_n | output | 7 | Active-low segments, bit 0 = a ... bit 6 = g |
| dp_n | output | 1 | Active-low decimal point, held off |
| an_n | output | 4 | Active-low digit enables, one low at a time |

## Verification
Every nibble value is shown as unsigned X against the same nibble as signed Y. This covers the full glyph table, and it shows that a set top bit alone does not bring in the minus sign. Positive signed values are compared with unsigned ones to confirm that the flag by itself changes nothing. The values 4'b1111 and 4'b1001 check negation away from the extreme, and 4'b1000 checks the case whose negation is itself. Each case is observed over a full refresh frame, so a swapped digit position or a swapped anode shows up as a wrong pattern in a named slot.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

    localparam int NIB_W  = 4;
    localparam int SEG_W  = 7;
    localparam int DIGITS = 4;

    localparam logic [SEG_W-1:0] SEG_BLANK = 7'h7F;
    localparam logic [SEG_W-1:0] SEG_MINUS = 7'b0111111;

    typedef enum logic [1:0] {
        SLOT_SIGN_X = 2'd0,
        SLOT_MAG_X  = 2'd1,
        SLOT_SIGN_Y = 2'd2,
        SLOT_MAG_Y  = 2'd3
    } slot_e;

    typedef struct packed {
        logic             neg;
        logic [NIB_W-1:0] mag;
    } signmag_t;

    // Active-low hex glyph, bit 0 = a ... bit 6 = g
    function automatic logic [SEG_W-1:0] hex_glyph_n(input logic [NIB_W-1:0] h);
        logic [SEG_W-1:0] on;
        case (h)
            4'h0: on = 7'h3F;
            4'h1: on = 7'h06;
            4'h2: on = 7'h5B;
            4'h3: on = 7'h4F;
            4'h4: on = 7'h66;
            4'h5: on = 7'h6D;
            4'h6: on = 7'h7D;
            4'h7: on = 7'h07;
            4'h8: on = 7'h7F;
            4'h9: on = 7'h6F;
            4'hA: on = 7'h77;
            4'hB: on = 7'h7C;
            4'hC: on = 7'h39;
            4'hD: on = 7'h5E;
            4'hE: on = 7'h79;
            default: on = 7'h71;
        endcase
        return ~on;
    endfunction

    function automatic logic [DIGITS-1:0] slot_anode_n(input slot_e s);
        logic [DIGITS-1:0] a;
        a = '1;
        a[s] = 1'b0;
        return a;
    endfunction

endpackage

// File: rtl/sdd_signmag.sv
module sdd_signmag
    import sdd_pkg::*;
(
    input  logic [NIB_W-1:0] val,
    input  logic             signed_mode,
    output signmag_t         sm
);
    logic is_neg;

    always_comb begin
        is_neg = signed_mode & val[NIB_W-1];
        sm.neg = is_neg;
        sm.mag = is_neg ? (~val + NIB_W'(1)) : val;
    end
endmodule

// File: rtl/sdd_scan.sv
module sdd_scan
    import sdd_pkg::*;
#(
    parameter int REFRESH_W = 16
) (
    input  logic  clk,
    input  logic  rst,
    output slot_e slot
);
    localparam int TOP = REFRESH_W - 1;

    logic [REFRESH_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + REFRESH_W'(1);
    end

    assign slot = slot_e'(cnt[TOP -: 2]);
endmodule

// File: rtl/sdd_digit_mux.sv
module sdd_digit_mux
    import sdd_pkg::*;
(
    input  slot_e             slot,
    input  signmag_t          sm_x,
    input  signmag_t          sm_y,
    output logic [SEG_W-1:0]  seg_n_nxt,
    output logic [DIGITS-1:0] an_n_nxt
);
    always_comb begin
        unique case (slot)
            SLOT_SIGN_X: seg_n_nxt = sm_x.neg ? SEG_MINUS : SEG_BLANK;
            SLOT_MAG_X:  seg_n_nxt = hex_glyph_n(sm_x.mag);
            SLOT_SIGN_Y: seg_n_nxt = sm_y.neg ? SEG_MINUS : SEG_BLANK;
            default:     seg_n_nxt = hex_glyph_n(sm_y.mag);
        endcase
        an_n_nxt = slot_anode_n(slot);
    end
endmodule

// File: rtl/signed_pair_seg_driver.sv
module signed_pair_seg_driver
    import sdd_pkg::*;
#(
    parameter int REFRESH_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] val_x,
    input  logic [3:0] val_y,
    input  logic       sgn_x,
    input  logic       sgn_y,
    output logic [6:0] seg_n,
    output logic       dp_n,
    output logic [3:0] an_n
);
    localparam int NVAL = 2;

    logic [NVAL-1:0][NIB_W-1:0] vals;
    logic [NVAL-1:0]            modes;
    signmag_t                   sm [NVAL];
    slot_e                      slot;
    logic [SEG_W-1:0]           seg_d;
    logic [DIGITS-1:0]          an_d;

    assign vals  = {val_y, val_x};
    assign modes = {sgn_y, sgn_x};

    for (genvar i = 0; i < NVAL; i++) begin : g_conv
        sdd_signmag u_conv (
            .val         (vals[i]),
            .signed_mode (modes[i]),
            .sm          (sm[i])
        );
    end

    sdd_scan #(.REFRESH_W(REFRESH_W)) u_scan (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    sdd_digit_mux u_mux (
        .slot      (slot),
        .sm_x      (sm[0]),
        .sm_y      (sm[1]),
        .seg_n_nxt (seg_d),
        .an_n_nxt  (an_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_n <= SEG_BLANK;
            an_n  <= '1;
        end else begin
            seg_n <= seg_d;
            an_n  <= an_d;
        end
    end

    assign dp_n = 1'b1;
endmodule

// File: rtl/sdd_checker.sv
module sdd_checker (
    input logic       clk,
    input logic       rst,
    input logic       x_msb,
    input logic       sgn_x,
    input logic [6:0] seg_n,
    input logic       dp_n,
    input logic [3:0] an_n
);
    logic started;

    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    assert_reset_blank_R1: assert property (@(posedge clk)
        rst |=> (an_n == 4'hF && seg_n == 7'h7F));

    assert_one_anode_R2: assert property (@(posedge clk) disable iff (rst)
        started |-> ($countones(~an_n) == 1));

    assert_slot_rotate_R2: assert property (@(posedge clk) disable iff (rst)
        (started && $past(started) && an_n != $past(an_n))
            |-> an_n == {$past(an_n[2:0]), $past(an_n[3])});

    assert_sign_blank_R3: assert property (@(posedge clk) disable iff (rst)
        (started && !an_n[0] && !$past(sgn_x)) |-> seg_n == 7'h7F);

    assert_minus_R5: assert property (@(posedge clk) disable iff (rst)
        (started && !an_n[0] && $past(sgn_x) && $past(x_msb)) |-> seg_n == 7'b0111111);

    assert_dp_off_R8: assert property (@(posedge clk) disable iff (rst)
        dp_n == 1'b1);
endmodule

bind signed_pair_seg_driver sdd_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .x_msb (val_x[3]),
    .sgn_x (sgn_x),
    .seg_n (seg_n),
    .dp_n  (dp_n),
    .an_n  (an_n)
);

// File: tb/signed_pair_seg_driver_tb.sv
module signed_pair_seg_driver_tb;

    localparam int RW   = 4;
    localparam int SLOT = 1 << (RW - 2);
    localparam int FRAME = 4 * SLOT;

    typedef struct {
        logic [6:0] seg [4];
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] val_x = 4'h0, val_y = 4'h0;
    logic       sgn_x = 1'b0, sgn_y = 1'b0;
    logic [6:0] seg_n;
    logic       dp_n;
    logic [3:0] an_n;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    logic [3:0] seen = 4'h0;

    always #4 clk = ~clk;

    signed_pair_seg_driver #(.REFRESH_W(RW)) u_dut (
        .clk(clk), .rst(rst), .val_x(val_x), .val_y(val_y),
        .sgn_x(sgn_x), .sgn_y(sgn_y), .seg_n(seg_n), .dp_n(dp_n), .an_n(an_n)
    );

    function automatic logic [6:0] glyph(input logic [3:0] h);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return ~t[h];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: apply values, let a frame pass, then post the expected digits
    task automatic show(input logic [3:0] x, input logic [3:0] y,
                        input logic sx, input logic sy, input string req);
        exp_t e;
        logic nx, ny;
        @(negedge clk);
        val_x = x; val_y = y; sgn_x = sx; sgn_y = sy;
        nx = sx & x[3];
        ny = sy & y[3];
        e.seg[0] = nx ? 7'b0111111 : 7'h7F;
        e.seg[1] = glyph(nx ? 4'(5'd16 - {1'b0, x}) : x);
        e.seg[2] = ny ? 7'b0111111 : 7'h7F;
        e.seg[3] = glyph(ny ? 4'(5'd16 - {1'b0, y}) : y);
        e.req = req;
        repeat (FRAME) @(negedge clk);
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    // Monitor: compare each digit slot against the head item
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            check($countones(~an_n) == 1, "R2", {28'd0, an_n}, 32'hE);
            check(dp_n == 1'b1, "R8", {31'd0, dp_n}, 32'd1);
            for (int i = 0; i < 4; i++) begin
                if (!an_n[i] && $countones(~an_n) == 1) begin
                    check(seg_n == q[0].seg[i], q[0].req, {25'd0, seg_n}, {25'd0, q[0].seg[i]});
                    seen[i] = 1'b1;
                end
            end
            if (seen == 4'hF) begin
                seen = 4'h0;
                void'(q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        val_x = 4'h9; sgn_x = 1'b1;
        repeat (3) @(negedge clk);
        check(an_n == 4'hF, "R1 anodes", {28'd0, an_n}, 32'hF);
        check(seg_n == 7'h7F, "R1 segments", {25'd0, seg_n}, 32'h7F);
        rst = 1'b0;
        // R1/R2: slot order from reset, SLOT clocks each
        for (int k = 1; k <= FRAME + SLOT; k++) begin
            @(negedge clk);
            check(an_n == ~(4'b0001 << (((k - 1) / SLOT) % 4)), "R2 order",
                  {28'd0, an_n}, {28'd0, ~(4'b0001 << (((k - 1) / SLOT) % 4))});
        end
        show(4'h3, 4'hC, 1'b0, 1'b0, "R3");
        show(4'hE, 4'hB, 1'b0, 1'b0, "R3");
        show(4'h5, 4'h7, 1'b1, 1'b1, "R4");
        show(4'hF, 4'h9, 1'b1, 1'b1, "R5");
        show(4'h8, 4'h8, 1'b1, 1'b0, "R6");
        show(4'hA, 4'hA, 1'b0, 1'b1, "R9");
        for (int v = 0; v < 16; v++)
            show(4'(v), 4'(v), 1'b0, 1'b1, "R7");
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule